// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the digital core of a 100-position digital potentiometer. Three pin levels arrive as synchronous samples: an active-low select, an active-low step strobe and a direction level. The block keeps the wiper position in a counter that never wraps. It turns that position into a one-hot enable for the tap switches of the resistor ladder.

A falling step strobe moves the wiper by one position. The move happens only while the part is selected. The direction level chooses whether the wiper goes up or down. Releasing the select while the strobe is high saves the position into a modelled persistent register, which keeps its contents through reset. Each reset reloads the wiper from that register. While the select is high the part is in standby and ignores the strobe.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: During reset and after it, `wiper_o` equals the last saved position. Before any save, that is the power-up value `NV_INIT` (default 0). During reset `store_o` is 0 and `standby_o` is 1.
- R2: `tap_o` has exactly one bit set, and that bit is at index `wiper_o` (bit 0 is the lowest position).
- R3: Each input passes through a two-stage synchroniser. A high-to-low change of `inc_n_i` with `cs_n_i` low moves `wiper_o` on the third rising clock edge after the change is first sampled. It moves up by one when `up_i` is 1 and down by one when `up_i` is 0.
- R4: While `cs_n_i` is high, falling edges of `inc_n_i` leave `wiper_o` unchanged.
- R5: The position saturates. A step up at 99 keeps it at 99, and a step down at 0 keeps it at 0.
- R6: A low-to-high change of `cs_n_i` while `inc_n_i` is high raises `store_o` for exactly one cycle. That cycle comes two clock edges after the change is first sampled. The current position is saved, and the next reset restores it.
- R7: A low-to-high change of `cs_n_i` while `inc_n_i` is low produces no `store_o` pulse and leaves the saved position unchanged.
- R8: `standby_o` follows `cs_n_i` with a two-cycle synchroniser delay.
- R9: Rising edges of `inc_n_i` and changes of `up_i` on their own do not move the wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the wiper from the saved position |
| cs_n_i | input | 1 | Active-low select sample |
| inc_n_i | input | 1 | Active-low step strobe sample |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| wiper_o | output | POS_W (7) | Current wiper position, 0 to TAPS-1 |
| tap_o | output | TAPS (100) | One-hot tap switch enables |
| store_o | output | 1 | One-cycle pulse when the position is saved |
| standby_o | output | 1 | High while the part is deselected |

## Verification
Some properties are checked on every cycle:
- the position stays in range and the tap vector stays one-hot at the wiper index;
- the position moves only by one step, and only after a detected falling strobe while selected;
- the position holds through standby and at both ends of the range;
- every save pulse follows a select release with the strobe high, and lasts one cycle.

Other behaviour shows only through the bench's scenarios. These are a select release with the strobe low that must not change the saved value, the value a later reset restores, and the exact synchroniser latency. The bench checks them against a reference model that replays the sampled pin history.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   // Idle levels of the three control pins: deselected, strobe high, count up.
   localparam logic CS_IDLE  = 1'b1;
   localparam logic INC_IDLE = 1'b1;
   localparam logic UP_IDLE  = 1'b1;

   typedef struct packed {
      logic cs_n;
      logic inc_n;
      logic up;
   } pins_t;

   localparam pins_t PINS_IDLE = '{cs_n: CS_IDLE, inc_n: INC_IDLE, up: UP_IDLE};

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dpot_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dpot_counter.sv
module dpot_counter #(
   parameter int TAPS  = 100,
   parameter int POS_W = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] load_val,
   input  logic             step,
   input  logic             up,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] TOP = POS_W'(TAPS - 1);

   logic at_top, at_bot;
   logic [POS_W-1:0] pos_nx;

   assign at_top = (pos == TOP);
   assign at_bot = (pos == '0);

   always_comb begin
      pos_nx = pos;
      if (step) begin
         if (up && !at_top)      pos_nx = pos + POS_W'(1);
         else if (!up && !at_bot) pos_nx = pos - POS_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pos <= load_val;
      else        pos <= pos_nx;
   end

   // R5: position never leaves the tap range
   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= TOP);

   // R3: any move needs a step request in the previous cycle
   a_r3_move_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != $past(pos)) |-> $past(step));

   // R5: no move past the upper end
   a_r5_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pos) == TOP && $past(up)) |-> pos == TOP);

   // R5: no move past the lower end
   a_r5_hold_bot: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pos) == '0 && !$past(up)) |-> pos == '0);

endmodule

// File: rtl/dpot_tap_decoder.sv
module dpot_tap_decoder #(
   parameter int TAPS  = 100,
   parameter int POS_W = $clog2(TAPS)
) (
   input  logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  taps
);

   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign taps[i] = (pos == POS_W'(i));
   end

endmodule

// File: rtl/dpot_wiper_ctrl.sv
module dpot_wiper_ctrl
   import dpot_pkg::*;
#(
   parameter int TAPS        = 100,
   parameter int SYNC_STAGES = 2,
   parameter int NV_INIT     = 0,
   parameter int POS_W       = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_i,
   input  logic             inc_n_i,
   input  logic             up_i,
   output logic [POS_W-1:0] wiper_o,
   output logic [TAPS-1:0]  tap_o,
   output logic             store_o,
   output logic             standby_o
);

   if (TAPS < 2 || TAPS > (1 << POS_W)) begin : g_bad_taps
      $error("dpot_wiper_ctrl: TAPS does not fit POS_W");
   end
   if (NV_INIT < 0 || NV_INIT >= TAPS) begin : g_bad_init
      $error("dpot_wiper_ctrl: NV_INIT outside tap range");
   end

   pins_t pins_raw, pins_s, pins_q;

   assign pins_raw = '{cs_n: cs_n_i, inc_n: inc_n_i, up: up_i};

   dpot_sync #(.WIDTH($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   // Previous synchronised levels for edge detection.
   always_ff @(posedge clk) begin
      if (!rst_n) pins_q <= PINS_IDLE;
      else        pins_q <= pins_s;
   end

   logic inc_fall, cs_rise, step, save;

   assign inc_fall = pins_q.inc_n & ~pins_s.inc_n;
   assign cs_rise  = ~pins_q.cs_n & pins_s.cs_n;
   assign step     = inc_fall & ~pins_s.cs_n;
   assign save     = cs_rise & pins_s.inc_n;

   // Modelled persistent register: keeps its value through reset.
   logic [POS_W-1:0] nv_q = POS_W'(NV_INIT);
   logic [POS_W-1:0] pos;

   always_ff @(posedge clk) begin
      if (rst_n && save) nv_q <= pos;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) store_o <= 1'b0;
      else        store_o <= save;
   end

   dpot_counter #(.TAPS(TAPS), .POS_W(POS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_val (nv_q),
      .step     (step),
      .up       (pins_s.up),
      .pos      (pos)
   );

   dpot_tap_decoder #(.TAPS(TAPS), .POS_W(POS_W)) u_dec (
      .pos  (pos),
      .taps (tap_o)
   );

   assign wiper_o   = pos;
   assign standby_o = pins_s.cs_n;

   // R2: exactly one tap enabled, at the wiper index
   a_r2_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_o) == 1 && tap_o == (TAPS'(1) << wiper_o));

   // R4: deselected in the previous cycle means the wiper holds
   a_r4_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(standby_o) |-> $stable(wiper_o));

   // R6: a save pulse follows a select release with the strobe high
   a_r6_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
      store_o |-> ($past(cs_rise) && $past(pins_s.inc_n)));

   // R6: a save pulse lasts one cycle
   a_r6_store_single: assert property (@(posedge clk) disable iff (!rst_n)
      store_o |=> !store_o);

endmodule

// File: tb/test_dpot_wiper_ctrl.sv
module test_dpot_wiper_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int TAPS  = 100;
   localparam int POS_W = $clog2(TAPS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, inc_n = 1'b1, up = 1'b1;
   logic [POS_W-1:0] wiper;
   logic [TAPS-1:0]  taps;
   logic store, standby;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpot_wiper_ctrl #(.TAPS(TAPS)) i_dpot_wiper_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .inc_n_i(inc_n), .up_i(up),
      .wiper_o(wiper), .tap_o(taps), .store_o(store), .standby_o(standby)
   );

   int n_tests = 0, n_fail = 0;
   bit started = 0, done = 0;

   task automatic check(input int act, input int exp, input string tag);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: history of sampled pins {cs,inc,up}, newest first.
   logic [2:0] hist[$];
   int m_pos = 0, m_nv = 0, m_store = 0, m_stby = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {3'b111, 3'b111, 3'b111};
         m_pos = m_nv; m_store = 0; m_stby = 1;
         started = 1;
      end else begin
         logic [2:0] cur, prv;
         cur = hist[1]; prv = hist[2];
         m_store = 0;
         if (!cur[2] && prv[1] && !cur[1]) begin
            if (cur[0] && m_pos < TAPS-1) m_pos++;
            else if (!cur[0] && m_pos > 0) m_pos--;
         end
         if (cur[2] && !prv[2] && cur[1]) begin
            m_nv = m_pos; m_store = 1;
         end
         hist.push_front({cs_n, inc_n, up});
         void'(hist.pop_back());
         m_stby = hist[1][2];
      end
   end

   // Cycle-by-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (started && !done) begin
         check(wiper, m_pos, "R3 wiper vs model");
         check($countones(taps), 1, "R2 one-hot count");
         check(taps[m_pos], 1, "R2 tap at wiper");
         check(store, m_store, "R6 store vs model");
         check(standby, m_stby, "R8 standby vs model");
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulses(input int n, input logic dir);
      up = dir;
      for (int k = 0; k < n; k++) begin
         @(negedge clk); inc_n = 1'b0;
         repeat (4) @(negedge clk);
         inc_n = 1'b1;
         repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(wiper, 0, "R1 reset wiper");
      check(store, 0, "R1 reset store");
      check(standby, 1, "R1 reset standby");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3: step up and down while selected
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      check(standby, 0, "R8 selected");
      pulses(5, 1'b1);
      check(wiper, 5, "R3 up five");
      pulses(2, 1'b0);
      check(wiper, 3, "R3 down two");

      // R3 latency: the change lands on the third edge
      up = 1'b1;
      @(negedge clk); inc_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check(wiper, 3, "R3 not yet after two edges");
      @(negedge clk);
      check(wiper, 4, "R3 moved on third edge");
      inc_n = 1'b1;
      repeat (4) @(negedge clk);

      // R9: direction toggles and strobe rises alone do not step
      up = 1'b0; repeat (3) @(negedge clk);
      up = 1'b1; repeat (3) @(negedge clk);
      check(wiper, 4, "R9 no step from direction change");

      // R5: saturate at the top
      pulses(100, 1'b1);
      check(wiper, 99, "R5 top saturation");

      // R6: release select with strobe high saves 99
      cs_n = 1'b1;
      repeat (5) @(negedge clk);
      check(standby, 1, "R8 deselected");

      // R4: strobe edges ignored in standby
      pulses(3, 1'b0);
      check(wiper, 99, "R4 standby ignores strobe");

      // R7: release select with strobe low saves nothing
      cs_n = 1'b0; repeat (4) @(negedge clk);
      pulses(10, 1'b0);
      check(wiper, 89, "R3 down ten");
      inc_n = 1'b0; up = 1'b1; repeat (4) @(negedge clk);
      cs_n = 1'b1; repeat (5) @(negedge clk);
      check(store, 0, "R7 no store pulse");
      inc_n = 1'b1; repeat (4) @(negedge clk);
      do_reset();
      @(negedge clk);
      check(wiper, 99, "R6 R7 reload saved 99");

      // R5: saturate at the bottom
      cs_n = 1'b0; repeat (4) @(negedge clk);
      pulses(120, 1'b0);
      check(wiper, 0, "R5 bottom saturation");
      cs_n = 1'b1; repeat (5) @(negedge clk);
      do_reset();
      @(negedge clk);
      check(wiper, 0, "R1 reload saved 0");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int cyc = 0;
      while (cyc < 50000 && !done) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule